// File: doc/BRIEF.md
# Multi-Thread Instruction Line Requester with Retry Slot

This unit turns per-thread fetch addresses into whole-line read requests for an instruction memory port. It clears the line-offset bits of the fetch address, labels the request with the requesting thread and a small per-thread sequence id, and follows each thread through a three-state life: free, parked on a refused request, or awaiting the line. Only one refused request can be parked at a time, and the unit holds it in one shared slot. While that slot is occupied every thread is held off. When the memory side raises its retry strobe, the unit re-offers the parked request.

A squash for a thread cancels whatever that thread has outstanding. If the parked request belongs to that thread, the squash empties the slot and releases the hold. If the thread is awaiting a line, the squash makes the thread forget the id it was waiting on. Each response carries a thread and an id. A response whose id matches what its thread is awaiting completes that thread's access. Any other response is dropped and flagged.

The fetch side is a valid/ready pair. A fetch is taken in any cycle where both are high, and the address is not held beyond that cycle. The memory request is offered for one cycle only, with `mreq_valid` high, and the memory answers in that same cycle on `mreq_ready`. If the memory refuses, the request moves into the slot. The unit does not keep `mreq_valid` high while it waits: it offers the request again only in a cycle where `mem_retry` is high. Responses cannot be back-pressured. The retry strobe, the squash inputs and the status outputs are plain signals.

Top module: `ilr_unit`

## Requirements
- R1: When `mreq_valid` is high for a new fetch, `mreq_addr` equals `fetch_addr` with its low 6 bits (log2 of a 64-byte line) forced to zero, and `mreq_tid` equals `fetch_tid`.
- R2: A new request refused (`mreq_ready` low) is parked: from the next cycle `blocked` is 1 and the thread's 2-bit field in `thr_state` (bits 2t+1:2t) reads 1 (waiting for retry).
- R3: `fetch_ready` is 0 while `blocked` is 1, and while `irq_pending` is 1 with `fetch_phys` at 0.
- R4: In a cycle where `mem_retry` is high and a request is parked, the unit offers that request again with the same address, thread and id. If the memory accepts it, the next cycle shows the thread at state 2 (waiting for response) and `blocked` at 0.
- R5: `mem_retry` with no parked request issues nothing and changes no state.
- R6: A squash of the thread that owns the parked request empties the slot. From the next cycle `blocked` is 0 and that thread is at state 0 (free).
- R7: A squash of a thread waiting for a response returns it to state 0, and a later response carrying its old id is dropped (`rsp_drop`).
- R8: A response completes the access (`rsp_hit` for one cycle, the thread goes to state 0 the next cycle) only if its thread is at state 2 and its id equals that thread's outstanding id. Otherwise `rsp_drop` pulses.
- R9: Each thread's request ids start at 0 after reset and increase by one, modulo 2^ID_W, for each new fetch that thread issues, whether the memory accepts it or refuses it.
- R10: When the owning thread is squashed in the same cycle as `mem_retry`, nothing is offered to memory and the squash takes effect.
- R11: After reset all threads are at state 0 and `blocked` is 0. `fetch_ready` is 0 for a thread that is not at state 0 or that is squashed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch address offered |
| fetch_ready | output | 1 | Fetch address taken this cycle |
| fetch_tid | input | TID_W | Requesting thread |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_phys | input | 1 | Privileged/physical access, exempt from interrupt hold |
| irq_pending | input | 1 | Interrupt pending |
| mreq_valid | output | 1 | Line request offered this cycle |
| mreq_ready | input | 1 | Memory accepts the offered request |
| mreq_addr | output | ADDR_W | Line-aligned request address |
| mreq_tid | output | TID_W | Request thread |
| mreq_id | output | ID_W | Request sequence id |
| mem_retry | input | 1 | Memory invites a re-offer |
| squash_valid | input | 1 | Squash a thread |
| squash_tid | input | TID_W | Thread squashed |
| rsp_valid | input | 1 | Line response arrives |
| rsp_tid | input | TID_W | Response thread |
| rsp_id | input | ID_W | Response id |
| rsp_hit | output | 1 | Response matched and completes the access |
| rsp_drop | output | 1 | Response was stale and is discarded |
| blocked | output | 1 | Retry slot occupied, all fetch held |
| thr_state | output | 2*NTHR | Per-thread state: 0 free, 1 wait retry, 2 wait response |

## Verification
A wrong internal state appears at the ports in one of a few ways. If the slot or a thread's state is wrong, `fetch_ready` or the `thr_state` field is wrong in the very next cycle. If an id counter or a stored outstanding id is wrong, the effect stays hidden until the next request from that thread, which shows a wrong `mreq_id`, or until its response, which hits or drops the wrong way. The bench compares every output against a behavioural model on every cycle, so most faults are caught within one cycle of the response or re-offer that exposes them. The random phase mixes squashes, refusals and retries so that these exposing events happen often.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
  typedef enum logic [1:0] {
    TS_FREE   = 2'd0,
    TS_WRETRY = 2'd1,
    TS_WRSP   = 2'd2
  } thr_st_e;
endpackage

// File: rtl/ilr_retry_slot.sv
module ilr_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 2,
  parameter int ID_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save,
  input  logic [TID_W-1:0]  save_tid,
  input  logic [ADDR_W-1:0] save_addr,
  input  logic [ID_W-1:0]   save_id,
  input  logic              drop,
  output logic              occ,
  output logic [TID_W-1:0]  s_tid,
  output logic [ADDR_W-1:0] s_addr,
  output logic [ID_W-1:0]   s_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= 1'b0;
      s_tid  <= '0;
      s_addr <= '0;
      s_id   <= '0;
    end else if (save) begin
      occ    <= 1'b1;
      s_tid  <= save_tid;
      s_addr <= save_addr;
      s_id   <= save_id;
    end else if (drop) begin
      occ    <= 1'b0;
    end
  end
endmodule

// File: rtl/ilr_thread_ctx.sv
module ilr_thread_ctx
  import ilr_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            new_acc,
  input  logic            new_ref,
  input  logic            resend_acc,
  input  logic [ID_W-1:0] resend_id,
  input  logic            line_done,
  input  logic            kill,
  output thr_st_e         st,
  output logic [ID_W-1:0] next_id,
  output logic [ID_W-1:0] out_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= TS_FREE;
      next_id <= '0;
      out_id  <= '0;
    end else begin
      if (new_acc || new_ref) next_id <= next_id + 1'b1;
      if (kill) begin
        st <= TS_FREE;
      end else if (new_acc) begin
        st     <= TS_WRSP;
        out_id <= next_id;
      end else if (new_ref) begin
        st <= TS_WRETRY;
      end else if (resend_acc) begin
        st     <= TS_WRSP;
        out_id <= resend_id;
      end else if (line_done) begin
        st <= TS_FREE;
      end
    end
  end
endmodule

// File: rtl/ilr_issue_ctl.sv
module ilr_issue_ctl #(
  parameter int NTHR       = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 3,
  localparam int TID_W     = $clog2(NTHR),
  localparam int OFS_W     = $clog2(LINE_BYTES)
) (
  input  logic                 fetch_valid,
  input  logic [TID_W-1:0]     fetch_tid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 fetch_phys,
  input  logic                 irq_pending,
  input  logic [NTHR-1:0]      thr_free,
  input  logic [NTHR*ID_W-1:0] next_ids,
  input  logic                 occ,
  input  logic [TID_W-1:0]     s_tid,
  input  logic [ADDR_W-1:0]    s_addr,
  input  logic [ID_W-1:0]      s_id,
  input  logic                 mem_retry,
  input  logic                 mreq_ready,
  input  logic                 squash_valid,
  input  logic [TID_W-1:0]     squash_tid,
  output logic                 fetch_ready,
  output logic                 mreq_valid,
  output logic [ADDR_W-1:0]    mreq_addr,
  output logic [TID_W-1:0]     mreq_tid,
  output logic [ID_W-1:0]      mreq_id,
  output logic                 new_acc,
  output logic                 new_ref,
  output logic                 resend_acc,
  output logic                 owner_kill
);
  logic irq_hold, take, resend;
  logic [ADDR_W-1:0] aligned;

  assign aligned    = {fetch_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign irq_hold   = irq_pending && !fetch_phys;
  assign owner_kill = squash_valid && occ && (squash_tid == s_tid);
  assign fetch_ready = !occ && !irq_hold && thr_free[fetch_tid] &&
                       !(squash_valid && squash_tid == fetch_tid);
  assign take   = fetch_valid && fetch_ready;
  assign resend = mem_retry && occ && !owner_kill;

  always_comb begin
    mreq_valid = take || resend;
    if (resend) begin
      mreq_addr = s_addr;
      mreq_tid  = s_tid;
      mreq_id   = s_id;
    end else begin
      mreq_addr = aligned;
      mreq_tid  = fetch_tid;
      mreq_id   = next_ids[fetch_tid*ID_W +: ID_W];
    end
  end

  assign new_acc    = take && mreq_ready;
  assign new_ref    = take && !mreq_ready;
  assign resend_acc = resend && mreq_ready;
endmodule

// File: rtl/ilr_unit.sv
module ilr_unit
  import ilr_pkg::*;
#(
  parameter int NTHR       = 4,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 3,
  localparam int TID_W     = $clog2(NTHR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  output logic               fetch_ready,
  input  logic [TID_W-1:0]   fetch_tid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic               fetch_phys,
  input  logic               irq_pending,
  output logic               mreq_valid,
  input  logic               mreq_ready,
  output logic [ADDR_W-1:0]  mreq_addr,
  output logic [TID_W-1:0]   mreq_tid,
  output logic [ID_W-1:0]    mreq_id,
  input  logic               mem_retry,
  input  logic               squash_valid,
  input  logic [TID_W-1:0]   squash_tid,
  input  logic               rsp_valid,
  input  logic [TID_W-1:0]   rsp_tid,
  input  logic [ID_W-1:0]    rsp_id,
  output logic               rsp_hit,
  output logic               rsp_drop,
  output logic               blocked,
  output logic [2*NTHR-1:0]  thr_state
);
  logic              occ;
  logic [TID_W-1:0]  s_tid;
  logic [ADDR_W-1:0] s_addr;
  logic [ID_W-1:0]   s_id;
  logic new_acc, new_ref, resend_acc, owner_kill;
  logic [NTHR-1:0]      thr_free, hit_vec;
  logic [NTHR*ID_W-1:0] next_ids;

  ilr_issue_ctl #(.NTHR(NTHR), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ID_W(ID_W)) u_ctl (
    .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_addr(fetch_addr),
    .fetch_phys(fetch_phys), .irq_pending(irq_pending), .thr_free(thr_free),
    .next_ids(next_ids), .occ(occ), .s_tid(s_tid), .s_addr(s_addr), .s_id(s_id),
    .mem_retry(mem_retry), .mreq_ready(mreq_ready), .squash_valid(squash_valid),
    .squash_tid(squash_tid), .fetch_ready(fetch_ready), .mreq_valid(mreq_valid),
    .mreq_addr(mreq_addr), .mreq_tid(mreq_tid), .mreq_id(mreq_id),
    .new_acc(new_acc), .new_ref(new_ref), .resend_acc(resend_acc), .owner_kill(owner_kill)
  );

  ilr_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W), .ID_W(ID_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .save(new_ref), .save_tid(mreq_tid),
    .save_addr(mreq_addr), .save_id(mreq_id), .drop(owner_kill || resend_acc),
    .occ(occ), .s_tid(s_tid), .s_addr(s_addr), .s_id(s_id)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    thr_st_e         st;
    logic [ID_W-1:0] oid;
    logic            sel_f, sel_s, kill;

    assign sel_f = (fetch_tid == TID_W'(t));
    assign sel_s = (s_tid == TID_W'(t));
    assign kill  = squash_valid && (squash_tid == TID_W'(t));
    assign hit_vec[t] = rsp_valid && (rsp_tid == TID_W'(t)) && (st == TS_WRSP) &&
                        (rsp_id == oid) && !kill;

    ilr_thread_ctx #(.ID_W(ID_W)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .new_acc(new_acc && sel_f), .new_ref(new_ref && sel_f),
      .resend_acc(resend_acc && sel_s), .resend_id(s_id),
      .line_done(hit_vec[t]), .kill(kill),
      .st(st), .next_id(next_ids[t*ID_W +: ID_W]), .out_id(oid)
    );

    assign thr_free[t]        = (st == TS_FREE);
    assign thr_state[2*t +: 2] = st;
  end

  assign rsp_hit  = |hit_vec;
  assign rsp_drop = rsp_valid && !rsp_hit;
  assign blocked  = occ;
endmodule

// File: rtl/ilr_unit_chk.sv
module ilr_unit_chk #(
  parameter int NTHR = 4,
  parameter int ADDR_W = 32,
  parameter int LINE_BYTES = 64,
  parameter int TID_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic [ADDR_W-1:0] mreq_addr,
  input logic              mem_retry,
  input logic              squash_valid,
  input logic [TID_W-1:0]  squash_tid,
  input logic [TID_W-1:0]  s_tid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_drop,
  input logic              blocked
);
  localparam int OFS_W = $clog2(LINE_BYTES);

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_addr[OFS_W-1:0] == '0)); // R1
  AST_REFUSE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready && !blocked) |=> blocked); // R2
  AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !fetch_ready); // R3
  AST_EMPTY_RETRY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_retry && !blocked && !fetch_valid) |-> !mreq_valid); // R5
  AST_OWNER_SQUASH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && squash_valid && squash_tid == s_tid) |=> !blocked); // R6
  AST_RSP_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_drop})); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_drop)); // R8
  AST_SQUASH_BEATS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && mem_retry && squash_valid && squash_tid == s_tid) |-> !mreq_valid); // R10
endmodule

bind ilr_unit ilr_unit_chk #(.NTHR(NTHR), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .TID_W(TID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
  .mem_retry(mem_retry), .squash_valid(squash_valid), .squash_tid(squash_tid),
  .s_tid(s_tid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_drop(rsp_drop),
  .blocked(blocked)
);

// File: tb/ilr_unit_bench.sv
module ilr_unit_bench;
  localparam int NT = 4;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int TW = 2;

  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, fetch_phys = 0, irq_pending = 0;
  logic [TW-1:0] fetch_tid = 0, squash_tid = 0, rsp_tid = 0;
  logic [AW-1:0] fetch_addr = 0;
  logic mreq_ready = 0, mem_retry = 0, squash_valid = 0, rsp_valid = 0;
  logic [IW-1:0] rsp_id = 0;
  logic fetch_ready, mreq_valid, rsp_hit, rsp_drop, blocked;
  logic [AW-1:0] mreq_addr;
  logic [TW-1:0] mreq_tid;
  logic [IW-1:0] mreq_id;
  logic [2*NT-1:0] thr_state;

  ilr_unit #(.NTHR(NT), .ADDR_W(AW), .LINE_BYTES(64), .ID_W(IW)) u_ilr_unit (.*);

  always #4ns clk = ~clk;

  int total = 0, bad = 0;
  string ctx = "R11 reset";
  bit done = 0;

  int m_st[NT], m_oid[NT], m_nid[NT];
  bit m_sv; int m_stid, m_sid; logic [AW-1:0] m_saddr;
  int q_tid[$], q_id[$];
  bit e_fr, e_mv, e_hit, e_drop, e_res;
  logic [AW-1:0] e_addr; int e_tid, e_id;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_phys = 0; irq_pending = 0; mreq_ready = 0;
    mem_retry = 0; squash_valid = 0; rsp_valid = 0;
  endtask

  task automatic cyc();
    int st_packed;
    bit sq;
    #1;
    sq    = squash_valid;
    e_fr  = !m_sv && !(irq_pending && !fetch_phys) && m_st[fetch_tid] == 0 &&
            !(sq && squash_tid == fetch_tid);
    e_res = mem_retry && m_sv && !(sq && squash_tid == m_stid);
    e_mv  = (fetch_valid && e_fr) || e_res;
    if (e_res) begin e_addr = m_saddr; e_tid = m_stid; e_id = m_sid; end
    else begin e_addr = fetch_addr & ~32'h3f; e_tid = fetch_tid; e_id = m_nid[fetch_tid]; end
    e_hit  = rsp_valid && m_st[rsp_tid] == 2 && m_oid[rsp_tid] == rsp_id &&
             !(sq && squash_tid == rsp_tid);
    e_drop = rsp_valid && !e_hit;
    st_packed = 0;
    for (int t = 0; t < NT; t++) st_packed |= m_st[t] << (2*t);
    chk(fetch_ready == e_fr, "R3 fetch_ready", fetch_ready, e_fr);
    chk(mreq_valid == e_mv, "R4 mreq_valid", mreq_valid, e_mv);
    if (e_mv) begin
      chk(mreq_addr == e_addr, "R1 mreq_addr", mreq_addr, e_addr);
      chk(mreq_tid == e_tid, "R1 mreq_tid", mreq_tid, e_tid);
      chk(mreq_id == e_id, "R9 mreq_id", mreq_id, e_id);
    end
    chk(blocked == m_sv, "R2 blocked", blocked, m_sv);
    chk(thr_state == st_packed[2*NT-1:0], "R11 thr_state", thr_state, st_packed);
    chk(rsp_hit == e_hit, "R8 rsp_hit", rsp_hit, e_hit);
    chk(rsp_drop == e_drop, "R7 rsp_drop", rsp_drop, e_drop);
    @(posedge clk);
    if (fetch_valid && e_fr) begin
      if (mreq_ready) begin
        m_st[fetch_tid] = 2; m_oid[fetch_tid] = m_nid[fetch_tid];
        q_tid.push_back(fetch_tid); q_id.push_back(m_nid[fetch_tid]);
      end else begin
        m_sv = 1; m_stid = fetch_tid; m_sid = m_nid[fetch_tid];
        m_saddr = fetch_addr & ~32'h3f; m_st[fetch_tid] = 1;
      end
      m_nid[fetch_tid] = (m_nid[fetch_tid] + 1) % (1 << IW);
    end
    if (e_res && mreq_ready) begin
      m_st[m_stid] = 2; m_oid[m_stid] = m_sid; m_sv = 0;
      q_tid.push_back(m_stid); q_id.push_back(m_sid);
    end
    if (e_hit) m_st[rsp_tid] = 0;
    if (sq) begin
      m_st[squash_tid] = 0;
      if (m_sv && m_stid == squash_tid) m_sv = 0;
    end
    @(negedge clk);
  endtask

  task automatic fetch(int tid, logic [AW-1:0] a, bit rdy);
    idle(); fetch_valid = 1; fetch_tid = TW'(tid); fetch_addr = a; mreq_ready = rdy; cyc();
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog [%s] act=0 exp=1", ctx);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_st[t] = 0; m_oid[t] = 0; m_nid[t] = 0; end
    m_sv = 0; m_stid = 0; m_sid = 0; m_saddr = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    ctx = "R11 after reset"; cyc();
    ctx = "R1 aligned issue"; fetch(1, 32'h1234_5677, 1);
    ctx = "R11 busy thread not ready"; fetch(1, 32'h40, 1);
    ctx = "R2 refusal parks"; fetch(2, 32'hABCD_EF3F, 0);
    ctx = "R3 held while blocked"; fetch(0, 32'h100, 1);
    ctx = "R4 refused re-offer"; idle(); mem_retry = 1; mreq_ready = 0; cyc();
    ctx = "R4 accepted re-offer"; idle(); mem_retry = 1; mreq_ready = 1; cyc();
    ctx = "R8 matching response"; idle(); rsp_valid = 1; rsp_tid = 2; rsp_id = 0; cyc();
    ctx = "R8 response to free thread"; idle(); rsp_valid = 1; rsp_tid = 2; rsp_id = 0; cyc();
    ctx = "R8 wrong id"; idle(); rsp_valid = 1; rsp_tid = 1; rsp_id = 5; cyc();
    ctx = "R3 interrupt hold"; fetch(0, 32'h200, 1); irq_pending = 1;
    idle(); irq_pending = 1; fetch_valid = 1; fetch_tid = 3; fetch_addr = 32'h300; mreq_ready = 1; cyc();
    ctx = "R3 physical passes interrupt";
    idle(); irq_pending = 1; fetch_phys = 1; fetch_valid = 1; fetch_tid = 3; fetch_addr = 32'h3C4; mreq_ready = 1; cyc();
    ctx = "R7 squash waiting thread"; idle(); squash_valid = 1; squash_tid = 1; cyc();
    ctx = "R7 stale response dropped"; idle(); rsp_valid = 1; rsp_tid = 1; rsp_id = 0; cyc();
    ctx = "R9 id advances"; fetch(1, 32'h5000, 1);
    ctx = "R10 park then squash with retry"; fetch(2, 32'h6000, 0);
    idle(); mem_retry = 1; mreq_ready = 1; squash_valid = 1; squash_tid = 2; cyc();
    ctx = "R10 after"; cyc();
    ctx = "R6 owner squash"; fetch(2, 32'h7000, 0);
    idle(); squash_valid = 1; squash_tid = 2; cyc();
    ctx = "R5 retry with empty slot"; idle(); mem_retry = 1; mreq_ready = 1; cyc();
    cyc();
    ctx = "R11 squash same cycle as fetch";
    idle(); fetch_valid = 1; fetch_tid = 2; fetch_addr = 32'h80; mreq_ready = 1; squash_valid = 1; squash_tid = 2; cyc();
    q_tid.delete(); q_id.delete();
    ctx = "random mix R1 R2 R4 R6 R7 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      idle();
      fetch_valid = ($urandom % 10) < 6;
      fetch_tid = TW'($urandom); fetch_addr = $urandom;
      fetch_phys = $urandom % 2; irq_pending = ($urandom % 10) == 0;
      mreq_ready = ($urandom % 10) < 6;
      mem_retry = ($urandom % 10) < 3;
      squash_valid = ($urandom % 10) == 0; squash_tid = TW'($urandom);
      if (q_tid.size() > 0 && ($urandom % 2)) begin
        rsp_valid = 1; rsp_tid = TW'(q_tid.pop_front()); rsp_id = IW'(q_id.pop_front());
        if (($urandom % 10) == 0) rsp_id = rsp_id + 1'b1;
      end else if (($urandom % 20) == 0) begin
        rsp_valid = 1; rsp_tid = TW'($urandom); rsp_id = IW'($urandom);
      end
      cyc();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule